// File: doc/BRIEF.md
# Multicycle processor control sequencer

This block is the central state machine of a small multicycle processor whose datapath is eight bits wide while its instructions are thirty-two bits wide. Each instruction is fetched one byte per cycle over four cycles. It is then decoded and carried out in one to three more cycles, depending on its class.

The sequencer reads a 6-bit opcode and the ALU zero flag. From these it drives every datapath control: memory read and write, the memory address source, four instruction-register byte enables, the register-file controls, the ALU operand selects and operation class, and the PC source. It also produces the merged PC load enable.

Five instruction classes are handled: byte load, byte store, register-register ALU operations, branch on equal, and unconditional jump. Reset is synchronous and returns the machine to the first fetch cycle.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle is the first fetch cycle. In that cycle `mem_rd`=1, `ir_we`=4'b1000, `alu_b_sel`=01 and `pc_wr`=1, with every other control at 0.
- R2: Fetch takes four consecutive cycles. Their `ir_we` values are 1000, 0100, 0010 and 0001, in that order. In each of them `mem_rd`=1, `addr_sel`=0 (PC), `alu_a_sel`=0, `alu_b_sel`=01, `alu_class`=00, `pc_src`=00 and `pc_wr`=1, with all other controls at 0.
- R3: The cycle after the last fetch is decode. In it `alu_a_sel`=0, `alu_b_sel`=11 and `alu_class`=00, with all other controls at 0.
- R4: A load (opcode 100000) runs three cycles after decode:
  - address computation: `alu_a_sel`=1, `alu_b_sel`=10, `alu_class`=00;
  - data read: `mem_rd`=1, `addr_sel`=1;
  - write-back: `rf_we`=1, `rf_dst_sel`=0, `rf_from_mem`=1.
  It then returns to the first fetch cycle.
- R5: A store (opcode 101000) runs the same address computation cycle, then one cycle with `mem_wr`=1 and `addr_sel`=1, then returns to fetch. In the address cycle, any opcode other than 100000 selects the store path. `mem_rd` and `mem_wr` are never high together.
- R6: A register-register operation (opcode 000000) runs two cycles after decode, then returns to fetch:
  - `alu_a_sel`=1, `alu_b_sel`=00, `alu_class`=10;
  - `rf_we`=1, `rf_dst_sel`=1, `rf_from_mem`=0.
- R7: Branch on equal (opcode 000100) runs one cycle after decode, then returns to fetch. In that cycle `alu_a_sel`=1, `alu_b_sel`=00, `alu_class`=01, `pc_wr_cond`=1 and `pc_src`=01.
- R8: A jump (opcode 000010) runs one cycle after decode, then returns to fetch. In that cycle `pc_wr`=1 and `pc_src`=10.
- R9: In every cycle, `pc_en` is 1 exactly when `pc_wr` is 1, or when `pc_wr_cond` and `alu_zero` are both 1.
- R10: Any opcode not listed above, when seen in decode, sends the machine straight back to the first fetch cycle.
- R11: The opcode is examined only in the decode and address-computation cycles. Changing it in any other cycle has no effect on outputs or sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Instruction opcode field |
| alu_zero | input | 1 | ALU result-is-zero flag |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| addr_sel | output | 1 | Memory address source: 0 = PC, 1 = ALU result register |
| ir_we | output | 4 | Instruction register byte enables |
| rf_we | output | 1 | Register file write |
| rf_dst_sel | output | 1 | Destination field select: 0 = second source field, 1 = destination field |
| rf_from_mem | output | 1 | Write-back data: 1 = memory data, 0 = ALU result |
| alu_a_sel | output | 1 | ALU A operand: 0 = PC, 1 = register A |
| alu_b_sel | output | 2 | ALU B operand select |
| alu_class | output | 2 | ALU operation class: 00 add, 01 subtract, 10 by function field |
| pc_src | output | 2 | PC next-value source |
| pc_wr | output | 1 | Unconditional PC write |
| pc_wr_cond | output | 1 | Conditional PC write |
| pc_en | output | 1 | Merged PC load enable |

## Verification
The bench targets the following corner cases:
- Byte-enable order across the four fetch cycles. A design that rotated the order or missed a step would load instruction bytes into the wrong lanes.
- Branches with the zero flag both set and clear. A wrong merge would either always take the branch or never take it.
- The zero flag toggled during jumps and fetches. This shows `pc_en` follows `pc_wr` alone outside branches.
- Unknown opcodes, which a faulty decoder would send into some execution path.
- Opcodes scrambled outside decode. A design that sampled the opcode late would drift into the wrong path.
- A reset asserted in the middle of a load, which must abandon the instruction at once.

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm (
  input  logic       clk,
  input  logic       rst,
  input  logic [5:0] opcode,
  input  logic       alu_zero,
  output logic       mem_rd,
  output logic       mem_wr,
  output logic       addr_sel,
  output logic [3:0] ir_we,
  output logic       rf_we,
  output logic       rf_dst_sel,
  output logic       rf_from_mem,
  output logic       alu_a_sel,
  output logic [1:0] alu_b_sel,
  output logic [1:0] alu_class,
  output logic [1:0] pc_src,
  output logic       pc_wr,
  output logic       pc_wr_cond,
  output logic       pc_en
);
  localparam logic [5:0] OP_ALU = 6'b000000;
  localparam logic [5:0] OP_LD  = 6'b100000;
  localparam logic [5:0] OP_ST  = 6'b101000;
  localparam logic [5:0] OP_BEQ = 6'b000100;
  localparam logic [5:0] OP_JMP = 6'b000010;

  typedef enum logic [3:0] {
    F0 = 4'd0, F1 = 4'd1, F2 = 4'd2, F3 = 4'd3, DEC = 4'd4,
    ADR = 4'd5, LDM = 4'd6, LWB = 4'd7, STM = 4'd8,
    AEX = 4'd9, AWB = 4'd10, BEQ = 4'd11, JMP = 4'd12
  } st_t;

  st_t st, st_n;

  always_ff @(posedge clk)
    if (rst) st <= F0;
    else     st <= st_n;

  always_comb begin
    st_n = F0;
    case (st)
      F0:  st_n = F1;
      F1:  st_n = F2;
      F2:  st_n = F3;
      F3:  st_n = DEC;
      DEC: case (opcode)
             OP_LD, OP_ST: st_n = ADR;
             OP_ALU:       st_n = AEX;
             OP_BEQ:       st_n = BEQ;
             OP_JMP:       st_n = JMP;
             default:      st_n = F0;
           endcase
      ADR: st_n = (opcode == OP_LD) ? LDM : STM;
      LDM: st_n = LWB;
      AEX: st_n = AWB;
      default: st_n = F0;
    endcase
  end

  always_comb begin
    mem_rd = 1'b0; mem_wr = 1'b0; addr_sel = 1'b0; ir_we = 4'b0000;
    rf_we = 1'b0; rf_dst_sel = 1'b0; rf_from_mem = 1'b0;
    alu_a_sel = 1'b0; alu_b_sel = 2'b00; alu_class = 2'b00;
    pc_src = 2'b00; pc_wr = 1'b0; pc_wr_cond = 1'b0;
    case (st)
      F0, F1, F2, F3: begin
        mem_rd = 1'b1; alu_b_sel = 2'b01; pc_wr = 1'b1;
        ir_we = 4'b1000 >> st[1:0];
      end
      DEC: alu_b_sel = 2'b11;
      ADR: begin alu_a_sel = 1'b1; alu_b_sel = 2'b10; end
      LDM: begin mem_rd = 1'b1; addr_sel = 1'b1; end
      LWB: begin rf_we = 1'b1; rf_from_mem = 1'b1; end
      STM: begin mem_wr = 1'b1; addr_sel = 1'b1; end
      AEX: begin alu_a_sel = 1'b1; alu_class = 2'b10; end
      AWB: begin rf_we = 1'b1; rf_dst_sel = 1'b1; end
      BEQ: begin
        alu_a_sel = 1'b1; alu_class = 2'b01; pc_wr_cond = 1'b1; pc_src = 2'b01;
      end
      JMP: begin pc_wr = 1'b1; pc_src = 2'b10; end
      default: ;
    endcase
  end

  assign pc_en = pc_wr | (pc_wr_cond & alu_zero);

  assert_reset_fetch_R1: assert property (@(posedge clk) rst |=> (ir_we == 4'b1000));
  assert_fetch_b2_R2: assert property (@(posedge clk) disable iff (rst) ir_we[3] |=> ir_we[2]);
  assert_fetch_b1_R2: assert property (@(posedge clk) disable iff (rst) ir_we[2] |=> ir_we[1]);
  assert_fetch_b0_R2: assert property (@(posedge clk) disable iff (rst) ir_we[1] |=> ir_we[0]);
  assert_decode_R3: assert property (@(posedge clk) disable iff (rst) ir_we[0] |=> (alu_b_sel == 2'b11));
  assert_load_wb_R4: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && addr_sel) |=> (rf_we && rf_from_mem));
  assert_store_ret_R5: assert property (@(posedge clk) disable iff (rst) mem_wr |=> ir_we[3]);
  assert_rdwr_excl_R5: assert property (@(posedge clk) disable iff (rst) !(mem_rd && mem_wr));
  assert_branch_ret_R7: assert property (@(posedge clk) disable iff (rst) pc_wr_cond |=> ir_we[3]);
  assert_branch_en_R9: assert property (@(posedge clk) disable iff (rst)
    (pc_wr_cond && !alu_zero) |-> !pc_en);
endmodule

// File: tb/test_mc_ctrl_fsm.sv
module test_mc_ctrl_fsm;
  logic clk = 1'b0, rst = 1'b1, alu_zero = 1'b0;
  logic [5:0] opcode = 6'd0;
  logic mem_rd, mem_wr, addr_sel, rf_we, rf_dst_sel, rf_from_mem, alu_a_sel;
  logic pc_wr, pc_wr_cond, pc_en;
  logic [3:0] ir_we;
  logic [1:0] alu_b_sel, alu_class, pc_src;

  int checks = 0, fails = 0, ms = 0, cyc = 0;
  string tag = "R1";
  bit scr = 0, unk = 0;

  always #5 clk = ~clk;

  mc_ctrl_fsm i_mc_ctrl_fsm (.clk(clk), .rst(rst), .opcode(opcode), .alu_zero(alu_zero),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .addr_sel(addr_sel), .ir_we(ir_we), .rf_we(rf_we),
    .rf_dst_sel(rf_dst_sel), .rf_from_mem(rf_from_mem), .alu_a_sel(alu_a_sel),
    .alu_b_sel(alu_b_sel), .alu_class(alu_class), .pc_src(pc_src), .pc_wr(pc_wr),
    .pc_wr_cond(pc_wr_cond), .pc_en(pc_en));

  // packed order: rd wr asel ir[4] rfwe dst frommem a b[2] cls[2] src[2] pcw pcc
  function automatic logic [18:0] expect_of(int s);
    logic [18:0] e = '0;
    if (s < 4) begin e[18] = 1; e[15:12] = 4'b1000 >> s; e[7:6] = 2'b01; e[1] = 1; end
    else if (s == 4) e[7:6] = 2'b11;
    else if (s == 5) begin e[8] = 1; e[7:6] = 2'b10; end
    else if (s == 6) begin e[18] = 1; e[16] = 1; end
    else if (s == 7) begin e[11] = 1; e[9] = 1; end
    else if (s == 8) begin e[17] = 1; e[16] = 1; end
    else if (s == 9) begin e[8] = 1; e[5:4] = 2'b10; end
    else if (s == 10) begin e[11] = 1; e[10] = 1; end
    else if (s == 11) begin e[8] = 1; e[5:4] = 2'b01; e[0] = 1; e[3:2] = 2'b01; end
    else if (s == 12) begin e[1] = 1; e[3:2] = 2'b10; end
    return e;
  endfunction

  function automatic int next_of(int s, logic [5:0] op);
    if (s < 4) return s + 1;
    if (s == 4) begin
      if (op == 6'b100000 || op == 6'b101000) return 5;
      if (op == 6'b000000) return 9;
      if (op == 6'b000100) return 11;
      if (op == 6'b000010) return 12;
      return 0;
    end
    if (s == 5) return (op == 6'b100000) ? 6 : 8;
    if (s == 6) return 7;
    if (s == 9) return 10;
    return 0;
  endfunction

  function automatic string tag_of(int s);
    if (s < 4) return "R2";
    if (s == 4) return "R3";
    if (s == 5 || s == 6 || s == 7) return "R4";
    if (s == 8) return "R5";
    if (s == 9 || s == 10) return "R6";
    if (s == 11) return "R7";
    return "R8";
  endfunction

  task automatic check_now();
    logic [18:0] act, exp;
    logic exp_en;
    string t;
    act = {mem_rd, mem_wr, addr_sel, ir_we, rf_we, rf_dst_sel, rf_from_mem, alu_a_sel,
           alu_b_sel, alu_class, pc_src, pc_wr, pc_wr_cond};
    exp = expect_of(ms);
    t = (tag != "") ? tag : (unk ? "R10" : (scr ? "R11" : tag_of(ms)));
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s state %0d controls act=%b exp=%b", t, ms, act, exp);
    end
    exp_en = exp[1] | (exp[0] & alu_zero);
    checks++;
    if (pc_en !== exp_en) begin
      fails++;
      $display("FAIL R9 state %0d pc_en act=%b exp=%b", ms, pc_en, exp_en);
    end
  endtask

  task automatic cycle(input logic [5:0] op, input logic z, input logic r);
    int nx;
    @(negedge clk);
    opcode = op; alu_zero = z; rst = r;
    #1;
    check_now();
    nx = r ? 0 : next_of(ms, op);
    @(posedge clk);
    ms = nx;
    tag = "";
  endtask

  // zm: 0/1 fixed zero flag, 2 toggles every cycle
  task automatic run_instr(input logic [5:0] op, input int zm, input bit s, input bit u);
    logic [5:0] junk [4] = '{6'b000010, 6'b100000, 6'b000100, 6'b111011};
    int k = 0;
    scr = s; unk = u;
    do begin
      logic z = (zm == 2) ? logic'(k % 2) : logic'(zm);
      logic [5:0] o = (s && ms != 4 && ms != 5) ? junk[k % 4] : op;
      cycle(o, z, 1'b0);
      k++;
    end while (ms != 0);
    scr = 0; unk = 0;
  endtask

  initial begin
    @(posedge clk);
    ms = 0;
    tag = "R1"; cycle(6'd0, 1'b0, 1'b1);
    tag = "R1"; cycle(6'd0, 1'b0, 1'b1);
    tag = "R1"; cycle(6'd0, 1'b0, 1'b0);
    tag = "R2";
    while (ms != 0) cycle(6'b000010, 1'b1, 1'b0);
    run_instr(6'b100000, 2, 0, 0);
    run_instr(6'b101000, 2, 0, 0);
    run_instr(6'b000000, 2, 0, 0);
    run_instr(6'b000100, 1, 0, 0);
    run_instr(6'b000100, 0, 0, 0);
    run_instr(6'b000010, 2, 0, 0);
    run_instr(6'b111111, 1, 0, 1);
    run_instr(6'b100001, 0, 0, 1);
    run_instr(6'b100000, 2, 1, 0);
    run_instr(6'b000000, 2, 1, 0);
    run_instr(6'b000100, 1, 1, 0);
    run_instr(6'b101000, 1, 1, 0);
    while (ms != 6) cycle(6'b100000, 1'b0, 1'b0);
    cycle(6'b100000, 1'b0, 1'b1);
    tag = "R1"; cycle(6'b100000, 1'b0, 1'b0);
    while (ms != 0) cycle(6'b000100, 1'b1, 1'b0);
    run_instr(6'b000010, 0, 0, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      checks++; fails++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule